// File: doc/BRIEF.md
# Configurable Asynchronous Serial Port

This block is a full-duplex asynchronous serial port. A transmit path and a receive path work independently and share one baud tick generator. The generator divides the system clock by a programmable divisor to make a 16x oversampling tick, so the fastest bit rate is one sixteenth of the clock. Characters carry 7, 8 or 9 data bits, sent least significant bit first. They are framed by one low start bit, an optional even or odd parity bit and exactly one high stop bit.

Each direction has a holding register in front of its shift register. Software, or a DMA engine driven by the request strobes, can write the next character while the current one is still on the line, and can collect a received character while the next one is arriving. The receiver reports parity, framing and overrun errors. It tells a short break (a framing error on an all-zero character) from a long break (the line held low for more than two character times). A 9-bit multiprocessor mode can hide data characters until an address character arrives. Optional hardware flow control holds transmission while CTS is high and drives RTS from the receive holding register.

The transmitter state machine has these states:
- TX_IDLE, which moves to TX_START when the holding register is full and CTS allows.
- TX_START, which moves to TX_DATA.
- TX_DATA, which moves to TX_PAR when parity is on, or to TX_STOP when it is off.
- TX_PAR, which moves to TX_STOP.
- TX_STOP, which returns to TX_IDLE.

The receiver state machine has these states:
- RX_IDLE, which moves to RX_START when the line falls.
- RX_START, which returns to RX_IDLE if the line is high at the 8th sample, and otherwise moves to RX_DATA.
- RX_DATA, which moves to RX_PAR or RX_STOP.
- RX_PAR, which moves to RX_STOP.
- RX_STOP, which moves to RX_IDLE if the stop bit is high, or to RX_HOLD if it is low.
- RX_HOLD, which returns to RX_IDLE once the line is high again.

Top module: `uart_serport`

## Requirements
- R1: Frame format: the idle line and the stop bit are 1, the start bit is 0 and data is sent least significant bit first. The cfg_len codes are 0 for 7 bits, 1 for 8 bits and 2 for 9 bits. A received character appears on rx_rdata with unused upper bits at 0.
- R2: The cfg_par codes are 0 for no parity, 1 for even and 2 for odd. The parity bit follows the last data bit. Even makes the count of ones over the data and parity bits even. Odd makes it odd.
- R3: One bit lasts 16*baud_div clock cycles. The receiver accepts a start bit only if the line is still low at the 8th tick after the falling edge. A low pulse shorter than half a bit yields no character.
- R4: tx_empty is 1 while the transmit holding register is free. A tx_we write is accepted only then and clears tx_empty on the next cycle. A write while the holding register is full is ignored.
- R5: rx_ready rises when a received character is moved into the holding register. It stays high until rx_re is pulsed.
- R6: st_perr is set by a received character whose parity bit is wrong. It stays set until err_clr is pulsed.
- R7: st_ferr is set when the stop bit is sampled low. st_sbrk is set when that happens on a character whose data bits (and parity bit, if any) are all 0. Both stay set until err_clr.
- R8: st_lbrk is set when the line stays low for more than two character times (32*(2+bits+parity) ticks). It stays set until err_clr.
- R9: If a character completes while rx_ready is high and no rx_re is pulsed, st_oerr is set. The new character is discarded and rx_rdata keeps the older one.
- R10: With cfg_mp=1 and cfg_mpfilt=1 (9-bit characters), a character with bit 8 at 0 does not raise rx_ready. With cfg_mpfilt=0, every character is delivered.
- R11: With cfg_flow=1, no new character starts while cts_n is 1, and rts_n equals rx_ready. With cfg_flow=0, rts_n is 0 and cts_n is ignored.
- R12: irq_rx is rx_ready gated by ie_rx. irq_tx is tx_empty gated by ie_tx. irq_err is the OR of the error flags gated by ie_err.
- R13: dreq_tx pulses for one cycle when the transmit holding register hands its character to the shifter. dreq_rx pulses for one cycle when a character is loaded into the receive holding register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| baud_div | input | DIV_W | Clock cycles per oversampling tick (0 acts as 1) |
| cfg_len | input | 2 | Character length code |
| cfg_par | input | 2 | Parity mode code |
| cfg_flow | input | 1 | Enable CTS/RTS flow control |
| cfg_mp | input | 1 | Enable multiprocessor mode |
| cfg_mpfilt | input | 1 | Address filter: drop characters with bit 8 at 0 |
| ie_rx | input | 1 | Receive-ready interrupt enable |
| ie_tx | input | 1 | Transmit-empty interrupt enable |
| ie_err | input | 1 | Error interrupt enable |
| tx_we | input | 1 | Write strobe for the transmit holding register |
| tx_wdata | input | 9 | Character to send |
| tx_empty | output | 1 | Transmit holding register free |
| tx_idle | output | 1 | Transmit shifter idle |
| rx_re | input | 1 | Pop strobe for the receive holding register |
| rx_rdata | output | 9 | Received character |
| rx_ready | output | 1 | Receive holding register full |
| err_clr | input | 1 | Clear all error flags |
| st_perr | output | 1 | Parity error flag |
| st_ferr | output | 1 | Framing error flag |
| st_oerr | output | 1 | Overrun flag |
| st_sbrk | output | 1 | Short break flag |
| st_lbrk | output | 1 | Long break flag |
| irq_rx | output | 1 | Receive interrupt |
| irq_tx | output | 1 | Transmit interrupt |
| irq_err | output | 1 | Error interrupt |
| dreq_tx | output | 1 | Transmit DMA request strobe |
| dreq_rx | output | 1 | Receive DMA request strobe |
| txd | output | 1 | Serial output |
| rxd | input | 1 | Serial input (asynchronous) |
| cts_n | input | 1 | Clear to send, active low |
| rts_n | output | 1 | Ready to receive, active low |

## Verification
The properties assume that the configuration inputs (length, parity, flow and multiprocessor mode, divisor) change only while both paths are idle. They also assume that rx_re and err_clr are single-cycle pulses, and that cfg_mp is used only with 9-bit characters. The stimulus changes configuration only between frames, after the transmitter has drained and the receiver has been emptied. It pulses the pop and clear strobes for one cycle, and enables multiprocessor mode only with cfg_len set to 9 bits. Serial input is driven at exactly 16*baud_div cycles per bit, so sampling never depends on tolerance to rate mismatch.

// File: rtl/uart_serport_pkg.sv
package uart_serport_pkg;

    typedef enum logic [2:0] {
        TX_IDLE, TX_START, TX_DATA, TX_PAR, TX_STOP
    } tx_state_e;

    typedef enum logic [2:0] {
        RX_IDLE, RX_START, RX_DATA, RX_PAR, RX_STOP, RX_HOLD
    } rx_state_e;

    localparam int CHAR_W = 9;
    localparam int LOWC_W = 10;

    function automatic logic [3:0] char_bits(input logic [1:0] len);
        case (len)
            2'd0:    return 4'd7;
            2'd1:    return 4'd8;
            default: return 4'd9;
        endcase
    endfunction

    function automatic logic frame_parity(input logic [CHAR_W-1:0] d,
                                          input logic [3:0] n,
                                          input logic odd);
        logic p;
        p = odd;
        for (int i = 0; i < CHAR_W; i++)
            if (i < int'(n)) p = p ^ d[i];
        return p;
    endfunction

endpackage

// File: rtl/uart_serport_baud.sv
module uart_serport_baud #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    localparam int CW = DIV_W + 1;

    logic [DIV_W-1:0] cnt;
    logic [CW-1:0]    nxt;

    assign nxt = {1'b0, cnt} + CW'(1);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt  <= '0;
            tick <= 1'b0;
        end else if (nxt >= {1'b0, div}) begin
            cnt  <= '0;
            tick <= 1'b1;
        end else begin
            cnt  <= nxt[DIV_W-1:0];
            tick <= 1'b0;
        end
    end
endmodule

// File: rtl/uart_serport_tx.sv
module uart_serport_tx
    import uart_serport_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic [1:0]        len,
    input  logic [1:0]        par,
    input  logic              flow_en,
    input  logic              cts_n,
    input  logic              we,
    input  logic [CHAR_W-1:0] wdata,
    output logic              txd,
    output logic              thr_empty,
    output logic              idle,
    output logic              dreq
);
    tx_state_e         st;
    logic [3:0]        ph, bitn, n;
    logic [CHAR_W-1:0] sh, thr;
    logic              thr_full, pbit, par_en, odd;

    assign n      = char_bits(len);
    assign par_en = ^par;
    assign odd    = par[1] & ~par[0];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= TX_IDLE;
            ph       <= '0;
            bitn     <= '0;
            sh       <= '0;
            thr      <= '0;
            thr_full <= 1'b0;
            pbit     <= 1'b0;
            dreq     <= 1'b0;
        end else begin
            dreq <= 1'b0;
            if (we && !thr_full) begin
                thr      <= wdata;
                thr_full <= 1'b1;
            end
            unique case (st)
                TX_IDLE: begin
                    if (thr_full && (!flow_en || !cts_n)) begin
                        sh       <= thr;
                        pbit     <= frame_parity(thr, n, odd);
                        thr_full <= 1'b0;
                        dreq     <= 1'b1;
                        ph       <= '0;
                        st       <= TX_START;
                    end
                end
                TX_START: if (tick) begin
                    ph <= ph + 4'd1;
                    if (ph == 4'd15) begin
                        bitn <= '0;
                        st   <= TX_DATA;
                    end
                end
                TX_DATA: if (tick) begin
                    ph <= ph + 4'd1;
                    if (ph == 4'd15) begin
                        sh   <= sh >> 1;
                        bitn <= bitn + 4'd1;
                        if (bitn == n - 4'd1)
                            st <= par_en ? TX_PAR : TX_STOP;
                    end
                end
                TX_PAR: if (tick) begin
                    ph <= ph + 4'd1;
                    if (ph == 4'd15) st <= TX_STOP;
                end
                TX_STOP: if (tick) begin
                    ph <= ph + 4'd1;
                    if (ph == 4'd15) st <= TX_IDLE;
                end
                default: st <= TX_IDLE;
            endcase
        end
    end

    always_comb begin
        unique case (st)
            TX_START: txd = 1'b0;
            TX_DATA:  txd = sh[0];
            TX_PAR:   txd = pbit;
            default:  txd = 1'b1;
        endcase
        idle      = (st == TX_IDLE);
        thr_empty = !thr_full;
    end
endmodule

// File: rtl/uart_serport_rx.sv
module uart_serport_rx
    import uart_serport_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              rxd,
    input  logic [1:0]        len,
    input  logic [1:0]        par,
    input  logic              mp_en,
    input  logic              mp_filt,
    input  logic              re,
    input  logic              err_clr,
    output logic [CHAR_W-1:0] rdata,
    output logic              ready,
    output logic              perr,
    output logic              ferr,
    output logic              oerr,
    output logic              sbrk,
    output logic              lbrk,
    output logic              dreq
);
    rx_state_e         st;
    logic              rs1, rs2, pr, par_en, odd, take;
    logic [3:0]        ph, bitn, n;
    logic [4:0]        fb;
    logic [CHAR_W-1:0] sh;
    logic [LOWC_W-1:0] lowcnt, lim;

    assign n      = char_bits(len);
    assign par_en = ^par;
    assign odd    = par[1] & ~par[0];
    assign fb     = 5'd2 + {1'b0, n} + {4'd0, par_en};
    assign lim    = {fb, 5'b0};
    assign take   = !(mp_en && mp_filt && !sh[8]);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rs1    <= 1'b1;
            rs2    <= 1'b1;
            lowcnt <= '0;
        end else begin
            rs1 <= rxd;
            rs2 <= rs1;
            if (rs2) lowcnt <= '0;
            else if (tick && lowcnt != '1) lowcnt <= lowcnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st    <= RX_IDLE;
            ph    <= '0;
            bitn  <= '0;
            sh    <= '0;
            pr    <= 1'b0;
            rdata <= '0;
            ready <= 1'b0;
            perr  <= 1'b0;
            ferr  <= 1'b0;
            oerr  <= 1'b0;
            sbrk  <= 1'b0;
            lbrk  <= 1'b0;
            dreq  <= 1'b0;
        end else begin
            dreq <= 1'b0;
            if (re) ready <= 1'b0;
            if (err_clr) begin
                perr <= 1'b0;
                ferr <= 1'b0;
                oerr <= 1'b0;
                sbrk <= 1'b0;
                lbrk <= 1'b0;
            end
            if (!rs2 && tick && lowcnt == lim) lbrk <= 1'b1;
            unique case (st)
                RX_IDLE: if (!rs2) begin
                    ph <= '0;
                    st <= RX_START;
                end
                RX_START: if (tick) begin
                    ph <= ph + 4'd1;
                    if (ph == 4'd7) begin
                        if (rs2) st <= RX_IDLE;
                        else begin
                            ph   <= '0;
                            bitn <= '0;
                            sh   <= '0;
                            pr   <= 1'b0;
                            st   <= RX_DATA;
                        end
                    end
                end
                RX_DATA: if (tick) begin
                    ph <= ph + 4'd1;
                    if (ph == 4'd15) begin
                        sh[bitn] <= rs2;
                        bitn     <= bitn + 4'd1;
                        if (bitn == n - 4'd1)
                            st <= par_en ? RX_PAR : RX_STOP;
                    end
                end
                RX_PAR: if (tick) begin
                    ph <= ph + 4'd1;
                    if (ph == 4'd15) begin
                        pr <= rs2;
                        st <= RX_STOP;
                    end
                end
                RX_STOP: if (tick) begin
                    ph <= ph + 4'd1;
                    if (ph == 4'd15) begin
                        if (par_en && pr != frame_parity(sh, n, odd)) perr <= 1'b1;
                        if (!rs2) begin
                            ferr <= 1'b1;
                            if (sh == '0 && !pr) sbrk <= 1'b1;
                        end
                        if (take) begin
                            if (ready && !re) oerr <= 1'b1;
                            else begin
                                rdata <= sh;
                                ready <= 1'b1;
                                dreq  <= 1'b1;
                            end
                        end
                        st <= rs2 ? RX_IDLE : RX_HOLD;
                    end
                end
                RX_HOLD: if (rs2) st <= RX_IDLE;
                default: st <= RX_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/uart_serport.sv
module uart_serport
    import uart_serport_pkg::*;
#(
    parameter int DIV_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DIV_W-1:0]  baud_div,
    input  logic [1:0]        cfg_len,
    input  logic [1:0]        cfg_par,
    input  logic              cfg_flow,
    input  logic              cfg_mp,
    input  logic              cfg_mpfilt,
    input  logic              ie_rx,
    input  logic              ie_tx,
    input  logic              ie_err,
    input  logic              tx_we,
    input  logic [CHAR_W-1:0] tx_wdata,
    output logic              tx_empty,
    output logic              tx_idle,
    input  logic              rx_re,
    output logic [CHAR_W-1:0] rx_rdata,
    output logic              rx_ready,
    input  logic              err_clr,
    output logic              st_perr,
    output logic              st_ferr,
    output logic              st_oerr,
    output logic              st_sbrk,
    output logic              st_lbrk,
    output logic              irq_rx,
    output logic              irq_tx,
    output logic              irq_err,
    output logic              dreq_tx,
    output logic              dreq_rx,
    output logic              txd,
    input  logic              rxd,
    input  logic              cts_n,
    output logic              rts_n
);
    logic tick;

    uart_serport_baud #(.DIV_W(DIV_W)) u_baud (
        .clk(clk), .rst_n(rst_n), .div(baud_div), .tick(tick)
    );

    uart_serport_tx u_tx (
        .clk(clk), .rst_n(rst_n), .tick(tick), .len(cfg_len), .par(cfg_par),
        .flow_en(cfg_flow), .cts_n(cts_n), .we(tx_we), .wdata(tx_wdata),
        .txd(txd), .thr_empty(tx_empty), .idle(tx_idle), .dreq(dreq_tx)
    );

    uart_serport_rx u_rx (
        .clk(clk), .rst_n(rst_n), .tick(tick), .rxd(rxd), .len(cfg_len),
        .par(cfg_par), .mp_en(cfg_mp), .mp_filt(cfg_mpfilt), .re(rx_re),
        .err_clr(err_clr), .rdata(rx_rdata), .ready(rx_ready),
        .perr(st_perr), .ferr(st_ferr), .oerr(st_oerr), .sbrk(st_sbrk),
        .lbrk(st_lbrk), .dreq(dreq_rx)
    );

    always_comb begin
        rts_n   = cfg_flow & rx_ready;
        irq_rx  = ie_rx & rx_ready;
        irq_tx  = ie_tx & tx_empty;
        irq_err = ie_err & (st_perr | st_ferr | st_oerr | st_sbrk | st_lbrk);
    end
endmodule

// File: rtl/uart_serport_chk.sv
module uart_serport_chk (
    input logic clk,
    input logic rst_n,
    input logic tx_we,
    input logic tx_empty,
    input logic tx_idle,
    input logic txd,
    input logic cfg_flow,
    input logic cts_n,
    input logic rx_re,
    input logic rx_ready,
    input logic err_clr,
    input logic st_perr,
    input logic st_oerr,
    input logic dreq_tx,
    input logic dreq_rx
);
    // R4
    thr_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_we && tx_empty) |=> !tx_empty);

    // R1
    idle_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_idle |-> txd);

    // R11
    cts_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_flow && cts_n && tx_idle) |=> tx_idle);

    // R5
    rx_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_ready && !rx_re) |=> rx_ready);

    // R6
    perr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_perr && !err_clr) |=> st_perr);

    // R9
    ovr_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_oerr) |-> rx_ready);

    // R13
    rx_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_ready) |-> dreq_rx);

    // R13
    tx_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dreq_tx |=> !dreq_tx);
endmodule

bind uart_serport uart_serport_chk u_chk (
    .clk(clk), .rst_n(rst_n), .tx_we(tx_we), .tx_empty(tx_empty),
    .tx_idle(tx_idle), .txd(txd), .cfg_flow(cfg_flow), .cts_n(cts_n),
    .rx_re(rx_re), .rx_ready(rx_ready), .err_clr(err_clr),
    .st_perr(st_perr), .st_oerr(st_oerr), .dreq_tx(dreq_tx), .dreq_rx(dreq_rx)
);

// File: tb/uart_serport_tb.sv
module uart_serport_tb;
    localparam int CLK_PERIOD = 10;
    localparam int DIV        = 2;
    localparam int BIT        = 16 * DIV;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [15:0] baud_div;
    logic [1:0] cfg_len, cfg_par;
    logic       cfg_flow, cfg_mp, cfg_mpfilt, ie_rx, ie_tx, ie_err;
    logic       tx_we, rx_re, err_clr, rxd, cts_n;
    logic [8:0] tx_wdata, rx_rdata;
    logic       tx_empty, tx_idle, rx_ready;
    logic       st_perr, st_ferr, st_oerr, st_sbrk, st_lbrk;
    logic       irq_rx, irq_tx, irq_err, dreq_tx, dreq_rx, txd, rts_n;

    int total = 0, bad = 0, cyc = 0, n_dtx = 0, n_drx = 0, n_txf = 0;
    logic [8:0] rxq[$];
    logic [8:0] txq[$];
    bit mon_en = 0, pop_req = 0, txbusy = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    uart_serport u_dut (
        .clk(clk), .rst_n(rst_n), .baud_div(baud_div), .cfg_len(cfg_len),
        .cfg_par(cfg_par), .cfg_flow(cfg_flow), .cfg_mp(cfg_mp),
        .cfg_mpfilt(cfg_mpfilt), .ie_rx(ie_rx), .ie_tx(ie_tx), .ie_err(ie_err),
        .tx_we(tx_we), .tx_wdata(tx_wdata), .tx_empty(tx_empty),
        .tx_idle(tx_idle), .rx_re(rx_re), .rx_rdata(rx_rdata),
        .rx_ready(rx_ready), .err_clr(err_clr), .st_perr(st_perr),
        .st_ferr(st_ferr), .st_oerr(st_oerr), .st_sbrk(st_sbrk),
        .st_lbrk(st_lbrk), .irq_rx(irq_rx), .irq_tx(irq_tx), .irq_err(irq_err),
        .dreq_tx(dreq_tx), .dreq_rx(dreq_rx), .txd(txd), .rxd(rxd),
        .cts_n(cts_n), .rts_n(rts_n)
    );

    task automatic check(input bit ok, input string tag,
                         input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    function automatic int nbits(input logic [1:0] len);
        return (len == 2'd0) ? 7 : (len == 2'd1) ? 8 : 9;
    endfunction

    function automatic logic [8:0] mask(input logic [8:0] d, input int nb);
        logic [8:0] m;
        m = '0;
        for (int i = 0; i < nb; i++) m[i] = d[i];
        return m;
    endfunction

    function automatic logic bpar(input logic [8:0] d, input int nb, input logic [1:0] pm);
        logic p;
        p = (pm == 2'd2);
        for (int i = 0; i < nb; i++) p = p ^ d[i];
        return p;
    endfunction

    always @(posedge clk) begin
        cyc++;
        if (dreq_tx) n_dtx++;
        if (dreq_rx) n_drx++;
        if (cyc > 150000) begin
            total++;
            bad++;
            $display("FAIL watchdog act=%h exp=%h", cyc, 150000);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    // receive monitor: pops the holding register and compares with the scoreboard
    initial begin
        rx_re = 1'b0;
        forever begin
            @(negedge clk);
            if (rx_ready && (mon_en || pop_req) && !rx_re) begin
                if (mon_en) begin
                    if (rxq.size() == 0) check(1'b0, "R5 unexpected char", 16'(rx_rdata), 16'h0);
                    else begin
                        automatic logic [8:0] e = rxq.pop_front();
                        check(rx_rdata == e, "R1 rx data", 16'(rx_rdata), 16'(e));
                    end
                end
                rx_re = 1'b1;
            end else rx_re = 1'b0;
        end
    end

    // transmit monitor: decodes txd at mid-bit and compares with the scoreboard
    initial begin
        forever begin
            @(negedge clk);
            if (txd === 1'b0) begin
                automatic logic [8:0] d = '0;
                automatic int nb = nbits(cfg_len);
                txbusy = 1'b1;
                repeat (BIT/2) @(negedge clk);
                check(txd == 1'b0, "R3 start bit width", 16'(txd), 16'h0);
                for (int i = 0; i < nb; i++) begin
                    repeat (BIT) @(negedge clk);
                    d[i] = txd;
                end
                if (^cfg_par) begin
                    repeat (BIT) @(negedge clk);
                    check(txd == bpar(d, nb, cfg_par), "R2 tx parity", 16'(txd), 16'(bpar(d, nb, cfg_par)));
                end
                repeat (BIT) @(negedge clk);
                check(txd == 1'b1, "R1 tx stop", 16'(txd), 16'h1);
                n_txf++;
                if (txq.size() == 0) check(1'b0, "R4 extra tx frame", 16'(d), 16'h0);
                else begin
                    automatic logic [8:0] e = mask(txq.pop_front(), nb);
                    check(d == e, "R1 tx data", 16'(d), 16'(e));
                end
                txbusy = 1'b0;
            end
        end
    end

    task automatic send_rx(input logic [8:0] d, input bit flip, input bit stopv, input bit exp);
        automatic int nb = nbits(cfg_len);
        automatic logic p = bpar(d, nb, cfg_par) ^ flip;
        if (exp) rxq.push_back(mask(d, nb));
        @(negedge clk);
        rxd = 1'b0;
        repeat (BIT) @(negedge clk);
        for (int i = 0; i < nb; i++) begin
            rxd = d[i];
            repeat (BIT) @(negedge clk);
        end
        if (^cfg_par) begin
            rxd = p;
            repeat (BIT) @(negedge clk);
        end
        rxd = stopv;
        repeat (BIT) @(negedge clk);
        rxd = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic write_tx(input logic [8:0] d, input bit exp);
        @(negedge clk);
        tx_we = 1'b1;
        tx_wdata = d;
        if (exp) txq.push_back(d);
        @(negedge clk);
        tx_we = 1'b0;
    endtask

    task automatic wait_tx_done();
        for (int i = 0; i < 20000; i++) begin
            @(negedge clk);
            if (tx_idle && tx_empty && !txbusy && txq.size() == 0) break;
        end
        repeat (BIT) @(negedge clk);
        check(txq.size() == 0, "R4 tx drained", 16'(txq.size()), 16'h0);
    endtask

    task automatic pop();
        pop_req = 1'b1;
        repeat (3) @(negedge clk);
        pop_req = 1'b0;
    endtask

    task automatic clr_err();
        @(negedge clk);
        err_clr = 1'b1;
        @(negedge clk);
        err_clr = 1'b0;
    endtask

    initial begin
        automatic int d0;
        rst_n = 1'b0; baud_div = 16'(DIV); cfg_len = 2'd1; cfg_par = 2'd0;
        cfg_flow = 1'b0; cfg_mp = 1'b0; cfg_mpfilt = 1'b0;
        ie_rx = 1'b0; ie_tx = 1'b0; ie_err = 1'b0;
        tx_we = 1'b0; tx_wdata = '0; err_clr = 1'b0; rxd = 1'b1; cts_n = 1'b1;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // reset state (R1 R4 R5 R11)
        check(txd == 1'b1, "R1 reset txd", 16'(txd), 16'h1);
        check(tx_empty == 1'b1, "R4 reset tx_empty", 16'(tx_empty), 16'h1);
        check(rx_ready == 1'b0, "R5 reset rx_ready", 16'(rx_ready), 16'h0);
        check(rts_n == 1'b0, "R11 reset rts_n", 16'(rts_n), 16'h0);

        // R12 transmit interrupt masking
        check(irq_tx == 1'b0, "R12 irq_tx masked", 16'(irq_tx), 16'h0);
        ie_tx = 1'b1;
        @(negedge clk);
        check(irq_tx == 1'b1, "R12 irq_tx enabled", 16'(irq_tx), 16'h1);
        ie_tx = 1'b0;

        // R1 8N1 scoreboard traffic, cts ignored with flow off (R11)
        mon_en = 1;
        send_rx(9'h0A5, 0, 1, 1);
        send_rx(9'h03C, 0, 1, 1);
        write_tx(9'h05A, 1);
        wait_tx_done();

        // R1 R2 7-bit even parity
        cfg_len = 2'd0; cfg_par = 2'd1;
        send_rx(9'h055, 0, 1, 1);
        send_rx(9'h1FF, 0, 1, 1);
        write_tx(9'h02B, 1);
        wait_tx_done();

        // R1 R2 9-bit odd parity
        cfg_len = 2'd2; cfg_par = 2'd2;
        send_rx(9'h1A3, 0, 1, 1);
        write_tx(9'h0F1, 1);
        wait_tx_done();
        check(rxq.size() == 0, "R5 rx scoreboard empty", 16'(rxq.size()), 16'h0);

        // R4 R13 double buffering, third write ignored
        cfg_len = 2'd1; cfg_par = 2'd0;
        d0 = n_dtx; n_txf = 0;
        write_tx(9'h0A1, 1);
        repeat (3) @(negedge clk);
        write_tx(9'h0B2, 1);
        check(tx_empty == 1'b0, "R4 holding full", 16'(tx_empty), 16'h0);
        write_tx(9'h0C3, 0);
        wait_tx_done();
        check(n_txf == 2, "R4 ignored write", 16'(n_txf), 16'h2);
        check(n_dtx - d0 == 2, "R13 dreq_tx count", 16'(n_dtx - d0), 16'h2);
        mon_en = 0;

        // R6 parity error sticky, R12 error interrupt
        cfg_par = 2'd1; ie_err = 1'b1;
        send_rx(9'h013, 1, 1, 0);
        check(st_perr == 1'b1, "R6 parity error", 16'(st_perr), 16'h1);
        check(irq_err == 1'b1, "R12 irq_err", 16'(irq_err), 16'h1);
        check(rx_ready == 1'b1, "R5 ready held", 16'(rx_ready), 16'h1);
        pop();
        check(st_perr == 1'b1, "R6 still set", 16'(st_perr), 16'h1);
        clr_err();
        check(st_perr == 1'b0, "R6 cleared", 16'(st_perr), 16'h0);
        ie_err = 1'b0;

        // R7 framing error without break, then short break
        cfg_par = 2'd0;
        send_rx(9'h081, 0, 0, 0);
        check(st_ferr == 1'b1, "R7 framing error", 16'(st_ferr), 16'h1);
        check(st_sbrk == 1'b0, "R7 no break on data", 16'(st_sbrk), 16'h0);
        pop(); clr_err();
        send_rx(9'h000, 0, 0, 0);
        check(st_sbrk == 1'b1, "R7 short break", 16'(st_sbrk), 16'h1);
        check(st_lbrk == 1'b0, "R8 not long", 16'(st_lbrk), 16'h0);
        pop(); clr_err();

        // R8 long break: low for three character times
        @(negedge clk);
        rxd = 1'b0;
        repeat (30 * BIT) @(negedge clk);
        check(st_lbrk == 1'b1, "R8 long break", 16'(st_lbrk), 16'h1);
        rxd = 1'b1;
        repeat (BIT) @(negedge clk);
        pop(); clr_err();

        // R9 R13 overrun
        d0 = n_drx;
        send_rx(9'h011, 0, 1, 0);
        send_rx(9'h022, 0, 1, 0);
        check(st_oerr == 1'b1, "R9 overrun flag", 16'(st_oerr), 16'h1);
        check(rx_rdata == 9'h011, "R9 old char kept", 16'(rx_rdata), 16'h011);
        check(n_drx - d0 == 1, "R13 dreq_rx count", 16'(n_drx - d0), 16'h1);
        pop();
        check(rx_ready == 1'b0, "R9 new char dropped", 16'(rx_ready), 16'h0);
        clr_err();

        // R10 multiprocessor address filter
        cfg_len = 2'd2; cfg_mp = 1'b1; cfg_mpfilt = 1'b1;
        send_rx(9'h034, 0, 1, 0);
        check(rx_ready == 1'b0, "R10 data filtered", 16'(rx_ready), 16'h0);
        send_rx(9'h1C5, 0, 1, 0);
        check(rx_ready == 1'b1 && rx_rdata == 9'h1C5, "R10 address taken", 16'(rx_rdata), 16'h1C5);
        pop();
        cfg_mpfilt = 1'b0;
        send_rx(9'h066, 0, 1, 0);
        check(rx_ready == 1'b1 && rx_rdata == 9'h066, "R10 filter off", 16'(rx_rdata), 16'h066);
        ie_rx = 1'b1;
        @(negedge clk);
        check(irq_rx == 1'b1, "R12 irq_rx", 16'(irq_rx), 16'h1);
        pop();
        ie_rx = 1'b0; cfg_mp = 1'b0; cfg_len = 2'd1;

        // R11 flow control
        cfg_flow = 1'b1; cts_n = 1'b1;
        write_tx(9'h077, 0);
        repeat (5 * BIT) @(negedge clk);
        check(tx_idle == 1'b1 && txd == 1'b1, "R11 cts holds tx", 16'(tx_idle), 16'h1);
        txq.push_back(9'h077);
        cts_n = 1'b0;
        wait_tx_done();
        send_rx(9'h042, 0, 1, 0);
        check(rts_n == 1'b1, "R11 rts when full", 16'(rts_n), 16'h1);
        pop();
        @(negedge clk);
        check(rts_n == 1'b0, "R11 rts when empty", 16'(rts_n), 16'h0);
        cfg_flow = 1'b0;

        // R3 glitch shorter than half a bit
        @(negedge clk);
        rxd = 1'b0;
        repeat (6) @(negedge clk);
        rxd = 1'b1;
        repeat (12 * BIT) @(negedge clk);
        check(rx_ready == 1'b0, "R3 glitch rejected", 16'(rx_ready), 16'h0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule